// File: doc/BRIEF.md
# Serial Command Front End

This block is the serial slave that a host uses to reach the registers and queues of a bus interface device. The host lowers chip select and shifts in one command byte, most significant bit first. The top bit of that byte gives the direction. The rest of the byte selects the target. A data field follows, and its length depends on the target. The block runs in clock mode 0: the host samples on the rising serial clock edge, and the block changes its output on the falling edge.

The block oversamples chip select, serial clock and serial input on its own system clock, through a synchronizer. Toward the core of the device it gives a small set of interfaces:
- a one-byte register write strobe;
- a word push strobe for the transmit queue;
- a word pop strobe for a receive queue;
- a read port. The block shows the latched opcode and the index of the byte it needs next, and the core answers with that byte in the same cycle.

Top module: `spi_cmd_if`

## Requirements
- R1: After reset and whenever chip select is high, the output enable `spi_so_oe` is low, and no write, push or pop strobe fires.
- R2: While the eight command bits are shifted in, `spi_so_oe` is high and `spi_so` carries a dummy zero.
- R3: For a read opcode, the first reply bit is driven on the falling serial clock edge that follows the eighth command bit. Reply bytes go out most significant bit first. Byte k is the value of `rd_byte` while `rd_idx` equals k, with `rd_op` holding the command.
- R4: The reply length is set by the opcode: one byte for the register reads (0x84, 0x88, 0x8C, 0x90, 0x94, 0xB4, 0xD0, 0xD4), three for the priority reads (0xA4, 0xA8, 0xAC, 0xC4, 0xC8, 0xCC), four for the queue reads (0xA0, 0xC0) and 32 for the label table reads (0x98, 0xB8). Every bit after the last reply byte is zero.
- R5: Any other opcode with bit 7 clear, bits 1:0 clear and a nonzero value is a one-byte register write. After the first data byte, `wr_stb` pulses for one cycle with `wr_addr` equal to opcode bits 6:2 and `wr_data` equal to the byte. Later bytes are ignored.
- R6: Opcode 0x0C takes four data bytes. After the fourth byte, `push_stb` pulses once, and `push_word` holds the bytes with the first byte in bits 31:24.
- R7: A queue read pulses `pop_stb` exactly once, and only after all four reply bytes have been shifted out. A shorter transfer does not pop.
- R8: Raising chip select in the middle of a transfer ends it. `spi_so_oe` goes low, and an incomplete write or push produces no strobe.
- R9: Opcode 0xFF and every opcode not listed above is a no-operation. It produces no strobe and returns zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from host |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Output enable for `spi_so` (low means high impedance) |
| rd_op | output | 8 | Latched opcode for the read port |
| rd_idx | output | IDX_W | Index of the reply byte requested |
| rd_byte | input | 8 | Reply byte returned by the core |
| wr_stb | output | 1 | Register write strobe |
| wr_addr | output | 5 | Register write address |
| wr_data | output | 8 | Register write data |
| push_stb | output | 1 | Transmit queue push strobe |
| push_word | output | WORD_BYTES*8 | Word to push |
| pop_stb | output | 1 | Receive queue pop strobe |

## Verification
The bench targets three corner cases:
- The first reply bit. If the design loaded the reply one edge late, the host would read a shifted byte.
- The boundaries of the data length: a queue read cut one byte short, priority and table reads clocked past their length, and a register write followed by extra bytes. A design that counted lengths wrongly would pop early, show stale bits, or write twice.
- Chip select rising partway through a push. A design that got this wrong would leave its output driven or push half a word.

Random opcodes, including undefined ones, check that unknown commands stay silent.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int CMD_BITS = 8;

    typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_DATA, PH_DONE} phase_e;

    typedef enum logic [2:0] {
        K_NOP, K_WREG, K_WFIFO, K_RREG, K_RPRI, K_RFIFO, K_RTAB
    } kind_e;

    function automatic logic kind_is_read(input kind_e k);
        return (k == K_RREG) || (k == K_RPRI) || (k == K_RFIFO) || (k == K_RTAB);
    endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int          W        = 3,
    parameter int          STAGES   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[g] <= RST_VAL;
            else if (g == 0) stage_q[g] <= d_i;
            else             stage_q[g] <= stage_q[(g > 0) ? g-1 : 0];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int WORD_BYTES = 4,
    parameter int PRI_BYTES  = 3,
    parameter int TAB_BYTES  = 32
) (
    input  logic [CMD_BITS-1:0] op,
    output kind_e               kind,
    output logic [IDX_W-1:0]    nbytes
);
    always_comb begin
        kind   = K_NOP;
        nbytes = '0;
        unique case (op)
            8'h0C: begin kind = K_WFIFO; nbytes = IDX_W'(WORD_BYTES); end
            8'h98, 8'hB8: begin kind = K_RTAB; nbytes = IDX_W'(TAB_BYTES); end
            8'hA0, 8'hC0: begin kind = K_RFIFO; nbytes = IDX_W'(WORD_BYTES); end
            8'hA4, 8'hA8, 8'hAC, 8'hC4, 8'hC8, 8'hCC: begin
                kind = K_RPRI; nbytes = IDX_W'(PRI_BYTES);
            end
            8'h84, 8'h88, 8'h8C, 8'h90, 8'h94, 8'hB4, 8'hD0, 8'hD4: begin
                kind = K_RREG; nbytes = IDX_W'(1);
            end
            default: begin
                if (!op[7] && op[1:0] == 2'b00 && op != 8'h00) begin
                    kind = K_WREG; nbytes = IDX_W'(1);
                end
            end
        endcase
    end
endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
    import spi_cmd_pkg::*;
#(
    parameter int WORD_BYTES  = 4,
    parameter int PRI_BYTES   = 3,
    parameter int TAB_BYTES   = 32,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(TAB_BYTES + 1),
    localparam int WORD_W     = WORD_BYTES * 8,
    localparam int ADDR_W     = CMD_BITS - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic [7:0]        rd_op,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [7:0]        rd_byte,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              push_stb,
    output logic [WORD_W-1:0] push_word,
    output logic              pop_stb
);
    typedef struct packed {
        phase_e              phase;
        logic [2:0]          bit_cnt;
        logic [IDX_W-1:0]    idx;
        logic [7:0]          op;
        kind_e               kind;
        logic [IDX_W-1:0]    nbytes;
        logic [7:0]          rx_sh;
        logic [WORD_W-1:0]   word;
        logic [7:0]          tx_sh;
        logic                so;
        logic                oe;
        logic                sck_prev;
        logic                wr;
        logic [ADDR_W-1:0]   waddr;
        logic [7:0]          wdata;
        logic                push;
        logic                pop;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] pins_s;
    logic       cs_act, sck_s, si_s, sck_rise, sck_fall;
    logic [7:0] rx_byte;
    kind_e      dec_kind;
    logic [IDX_W-1:0] dec_n, idx_nx;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_cs_n, spi_sck, spi_si}),
        .q_o   (pins_s)
    );

    assign cs_act   = ~pins_s[2];
    assign sck_s    = pins_s[1];
    assign si_s     = pins_s[0];
    assign sck_rise = sck_s & ~st_q.sck_prev;
    assign sck_fall = ~sck_s & st_q.sck_prev;
    assign rx_byte  = {st_q.rx_sh[6:0], si_s};
    assign idx_nx   = st_q.idx + 1'b1;

    spi_cmd_decode #(
        .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES), .PRI_BYTES(PRI_BYTES), .TAB_BYTES(TAB_BYTES)
    ) i_dec (
        .op     (rx_byte),
        .kind   (dec_kind),
        .nbytes (dec_n)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wr       = 1'b0;
        st_d.push     = 1'b0;
        st_d.pop      = 1'b0;
        st_d.sck_prev = sck_s;
        if (!cs_act) begin
            st_d.phase   = PH_IDLE;
            st_d.oe      = 1'b0;
            st_d.so      = 1'b0;
            st_d.bit_cnt = '0;
            st_d.idx     = '0;
        end else if (st_q.phase == PH_IDLE) begin
            st_d.phase   = PH_CMD;
            st_d.oe      = 1'b1;
            st_d.so      = 1'b0;
            st_d.bit_cnt = '0;
        end else if (sck_rise) begin
            st_d.rx_sh   = rx_byte;
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (st_q.bit_cnt == 3'd7) begin
                if (st_q.phase == PH_CMD) begin
                    st_d.op     = rx_byte;
                    st_d.kind   = dec_kind;
                    st_d.nbytes = dec_n;
                    st_d.idx    = '0;
                    st_d.phase  = (dec_n == '0) ? PH_DONE : PH_DATA;
                end else if (st_q.phase == PH_DATA) begin
                    case (st_q.kind)
                        K_WREG: begin
                            st_d.wr    = 1'b1;
                            st_d.waddr = st_q.op[6:2];
                            st_d.wdata = rx_byte;
                        end
                        K_WFIFO: begin
                            st_d.word = {st_q.word[WORD_W-9:0], rx_byte};
                            st_d.push = (idx_nx == st_q.nbytes);
                        end
                        K_RFIFO: st_d.pop = (idx_nx == st_q.nbytes);
                        default: ;
                    endcase
                    st_d.idx = idx_nx;
                    if (idx_nx == st_q.nbytes) st_d.phase = PH_DONE;
                end
            end
        end else if (sck_fall) begin
            if (st_q.phase == PH_DATA && kind_is_read(st_q.kind)) begin
                if (st_q.bit_cnt == 3'd0) begin
                    st_d.so    = rd_byte[7];
                    st_d.tx_sh = {rd_byte[6:0], 1'b0};
                end else begin
                    st_d.so    = st_q.tx_sh[7];
                    st_d.tx_sh = {st_q.tx_sh[6:0], 1'b0};
                end
            end else begin
                st_d.so = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.kind  <= K_NOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_so    = st_q.so;
    assign spi_so_oe = st_q.oe;
    assign rd_op     = st_q.op;
    assign rd_idx    = st_q.idx;
    assign wr_stb    = st_q.wr;
    assign wr_addr   = st_q.waddr;
    assign wr_data   = st_q.wdata;
    assign push_stb  = st_q.push;
    assign push_word = st_q.word;
    assign pop_stb   = st_q.pop;

    phase_e phase_w;
    kind_e  kind_w;
    assign phase_w = st_q.phase;
    assign kind_w  = st_q.kind;
endmodule

// File: rtl/spi_cmd_if_chk.sv
module spi_cmd_if_chk
    import spi_cmd_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   spi_so,
    input logic   spi_so_oe,
    input logic   wr_stb,
    input logic   push_stb,
    input logic   pop_stb,
    input logic   sck_fall,
    input phase_e phase,
    input kind_e  kind
);
    assert_idle_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !spi_so_oe);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!wr_stb && !push_stb && !pop_stb));

    assert_dummy_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD) |-> !spi_so);

    assert_so_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_so_oe && !$stable(spi_so)) |-> $past(sck_fall));

    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_pop_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_stb |-> (kind == K_RFIFO));

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NOP && phase != PH_CMD) |-> (!wr_stb && !push_stb && !pop_stb && !spi_so));
endmodule

bind spi_cmd_if spi_cmd_if_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_so    (spi_so),
    .spi_so_oe (spi_so_oe),
    .wr_stb    (wr_stb),
    .push_stb  (push_stb),
    .pop_stb   (pop_stb),
    .sck_fall  (sck_fall),
    .phase     (phase_w),
    .kind      (kind_w)
);

// File: tb/test_spi_cmd_if.sv
`timescale 1ns/1ps
module test_spi_cmd_if;
    localparam int HALF  = 10;
    localparam int IDX_W = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0;
    logic spi_so, spi_so_oe, wr_stb, push_stb, pop_stb;
    logic [7:0] rd_op, rd_byte, wr_data;
    logic [IDX_W-1:0] rd_idx;
    logic [4:0] wr_addr;
    logic [31:0] push_word;

    int total = 0, bad = 0;
    int wr_cnt = 0, push_cnt = 0, pop_cnt = 0;
    logic [7:0] wdat [0:39];
    logic [7:0] rdat [0:39];
    bit dummy_ok, done_flag = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] dn_byte(input logic [7:0] op, input int idx);
        return op ^ 8'(idx * 37) ^ 8'h5A;
    endfunction

    // kinds: 0 nop, 1 reg write, 2 push, 3 reg read, 4 priority, 5 queue read, 6 table
    function automatic int exp_kind(input logic [7:0] op);
        case (op)
            8'h0C: return 2;
            8'h98, 8'hB8: return 6;
            8'hA0, 8'hC0: return 5;
            8'hA4, 8'hA8, 8'hAC, 8'hC4, 8'hC8, 8'hCC: return 4;
            8'h84, 8'h88, 8'h8C, 8'h90, 8'h94, 8'hB4, 8'hD0, 8'hD4: return 3;
            default: return (!op[7] && op[1:0] == 2'b00 && op != 8'h00) ? 1 : 0;
        endcase
    endfunction

    function automatic int exp_len(input int k);
        case (k)
            1, 3: return 1;
            2, 5: return 4;
            4: return 3;
            6: return 32;
            default: return 0;
        endcase
    endfunction

    assign rd_byte = dn_byte(rd_op, int'(rd_idx));

    spi_cmd_if i_spi_cmd_if (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_oe(spi_so_oe), .rd_op(rd_op), .rd_idx(rd_idx),
        .rd_byte(rd_byte), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .push_stb(push_stb), .push_word(push_word), .pop_stb(pop_stb)
    );

    always @(posedge clk) begin
        if (wr_stb)   wr_cnt   <= wr_cnt + 1;
        if (push_stb) push_cnt <= push_cnt + 1;
        if (pop_stb)  pop_cnt  <= pop_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clocks 8 + 8*nb - cut bits, then raises chip select and checks every result.
    task automatic xfer(input logic [7:0] op, input int nb, input int cut);
        int bits = 8 + 8 * nb - cut;
        int k = exp_kind(op);
        int len = exp_len(k);
        int complete = (bits >= 8) ? (bits - 8) / 8 : 0;
        int w0 = wr_cnt, p0 = push_cnt, q0 = pop_cnt;
        dummy_ok = 1;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_n(HALF);
        for (int i = 0; i < bits; i++) begin
            if (i < 8) spi_si = op[7 - i];
            else       spi_si = wdat[(i - 8) / 8][7 - ((i - 8) % 8)];
            wait_n(HALF);
            if (i < 8) begin
                if (spi_so !== 1'b0 || spi_so_oe !== 1'b1) dummy_ok = 0;
            end else begin
                rdat[(i - 8) / 8][7 - ((i - 8) % 8)] = spi_so;
            end
            spi_sck = 1'b1;
            wait_n(HALF);
            spi_sck = 1'b0;
        end
        wait_n(HALF);
        spi_cs_n = 1'b1;
        wait_n(3 * HALF);
        check(dummy_ok, "R2 dummy byte during command", dummy_ok, 1);
        for (int j = 0; j < complete; j++) begin
            logic [7:0] e = (k >= 3 && j < len) ? dn_byte(op, j) : 8'h00;
            check(rdat[j] === e, (j < len) ? "R3 R4 reply byte" : "R4 R9 zero after length",
                  rdat[j], e);
        end
        check(wr_cnt - w0 == ((k == 1 && complete >= 1) ? 1 : 0), "R5 R8 R9 write strobe count",
              wr_cnt - w0, (k == 1 && complete >= 1) ? 1 : 0);
        if (k == 1 && complete >= 1)
            check(wr_addr === op[6:2] && wr_data === wdat[0], "R5 write address/data",
                  {wr_addr, wr_data}, {op[6:2], wdat[0]});
        check(push_cnt - p0 == ((k == 2 && complete >= 4) ? 1 : 0), "R6 R8 push count",
              push_cnt - p0, (k == 2 && complete >= 4) ? 1 : 0);
        if (k == 2 && complete >= 4)
            check(push_word === {wdat[0], wdat[1], wdat[2], wdat[3]}, "R6 push word",
                  push_word, {wdat[0], wdat[1], wdat[2], wdat[3]});
        check(pop_cnt - q0 == ((k == 5 && complete >= 4) ? 1 : 0), "R7 pop count",
              pop_cnt - q0, (k == 5 && complete >= 4) ? 1 : 0);
        check(spi_so_oe === 1'b0, "R1 R8 output released", spi_so_oe, 0);
    endtask

    task automatic fill_random();
        for (int j = 0; j < 40; j++) wdat[j] = 8'($urandom);
    endtask

    initial begin
        logic [7:0] ops [0:13];
        ops = '{8'h84, 8'hD4, 8'hA4, 8'hCC, 8'hA0, 8'hC0, 8'h98, 8'hB8,
                8'h0C, 8'h10, 8'h3C, 8'hFF, 8'h7B, 8'hE1};
        void'($urandom(32'h1234_5678));
        wait_n(5);
        check(spi_so_oe === 1'b0 && wr_stb === 1'b0 && push_stb === 1'b0 && pop_stb === 1'b0,
              "R1 reset state", {spi_so_oe, wr_stb, push_stb, pop_stb}, 0);
        rst_n = 1'b1;
        wait_n(5);
        check(spi_so_oe === 1'b0, "R1 idle after reset", spi_so_oe, 0);

        fill_random();
        xfer(8'h84, 1, 0);          // R3 single byte read
        xfer(8'hA4, 4, 0);          // R4 priority read clocked one byte past length
        xfer(8'hA0, 4, 0);          // R7 full queue read pops
        xfer(8'hC0, 3, 0);          // R7 short queue read, no pop
        xfer(8'h98, 33, 0);         // R4 table read plus one extra byte
        xfer(8'h10, 2, 0);          // R5 write, second byte ignored
        xfer(8'h0C, 4, 0);          // R6 push
        xfer(8'h0C, 4, 4);          // R8 abort in last byte of push
        xfer(8'h20, 0, 3);          // R8 abort inside command byte
        xfer(8'hFF, 2, 0);          // R9 no-operation
        xfer(8'h7B, 2, 0);          // R9 undefined opcode

        for (int t = 0; t < 30; t++) begin
            logic [7:0] op = ops[$urandom_range(0, 13)];
            int nb = $urandom_range(0, 5);
            int cut = 0;
            if (exp_kind(op) == 6) nb = $urandom_range(0, 33);
            if ($urandom_range(0, 3) == 0) cut = $urandom_range(1, 7);
            if (nb == 0 && cut > 0) cut = 0;
            fill_random();
            xfer(op, nb, cut);
        end
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done_flag) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule